// File: doc/BRIEF.md
# Transmit-Gated I/Q Sample FIFO

This block holds complex baseband samples, each a 16-bit in-phase and a 16-bit quadrature word, between the producer that writes them and the core that consumes them. Both sides run on one clock; the producer pulses a write enable and the consumer raises a read request. The block keeps a fill level and reports full, empty, a sticky overflow and a sticky underflow. It also compares the level against an upper and a lower limit that software programs.

Whether a read request is honoured depends on a mode input. In automatic mode the FIFO arms itself once it has held two samples since reset, and every read request after that is served. In gated mode an external transmit-enable input decides, cycle by cycle, whether reads may happen. A second mode input picks what a single status output shows: the underflow flag or the empty flag.

Top module: `iq_sample_fifo`

## Requirements
- R1: Samples leave in the order they were written, as {I, Q}; an accepted read makes `rd_valid` high on the next cycle with the oldest sample on `rd_i`/`rd_q`, and the read data holds its value in every cycle after which no read was accepted.
- R2: With `cfg_txen_gate` = 0, `txen` has no effect and read requests are ignored until the fill level has first reached 2 since reset; from the following cycle on, a read request is accepted whenever the FIFO is not empty.
- R3: With `cfg_txen_gate` = 1, a read request is acted on only in a cycle where `txen` = 1; with `txen` = 0 it neither removes a sample nor sets underflow.
- R4: `level` gives the number of samples held (0 to 256); `full` is 1 exactly when it is 256 and `empty` exactly when it is 0; a cycle with both an accepted write and an accepted read leaves the level unchanged.
- R5: A write while `full` = 1 is dropped, even if a read is accepted in the same cycle, and sets `overflow`, which stays 1 until cleared.
- R6: A read request that is permitted by the mode while `empty` = 1 removes nothing and sets `underflow`, which stays 1 until cleared.
- R7: `clr_flags` = 1 clears both sticky flags on the next edge; an overflow or underflow event in the same cycle wins and leaves its flag set.
- R8: `stat_out` shows `underflow` when `cfg_stat_empty` = 0 and `empty` when `cfg_stat_empty` = 1.
- R9: `above_upper` is 1 when the level is greater than or equal to the 8-bit `thr_upper`; `below_lower` is 1 when the level is less than or equal to the 8-bit `thr_lower`.
- R10: During and right after reset the FIFO is empty with level 0, both sticky flags at 0, `rd_valid` at 0, read data at 0 and automatic mode disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one sample this cycle |
| wr_i | input | 16 | In-phase word to write |
| wr_q | input | 16 | Quadrature word to write |
| rd_req | input | 1 | Request to read one sample |
| txen | input | 1 | Transmit enable, gates reads in gated mode |
| cfg_txen_gate | input | 1 | 1 = reads gated by `txen`, 0 = automatic start |
| cfg_stat_empty | input | 1 | 1 = `stat_out` shows empty, 0 = underflow |
| thr_upper | input | 8 | Upper fill limit |
| thr_lower | input | 8 | Lower fill limit |
| clr_flags | input | 1 | Clear overflow and underflow |
| rd_i | output | 16 | In-phase word read |
| rd_q | output | 16 | Quadrature word read |
| rd_valid | output | 1 | Read data updated by the previous cycle's read |
| level | output | 9 | Samples currently held |
| full | output | 1 | FIFO holds 256 samples |
| empty | output | 1 | FIFO holds no sample |
| overflow | output | 1 | Sticky: write attempted while full |
| underflow | output | 1 | Sticky: permitted read while empty |
| stat_out | output | 1 | Underflow or empty, chosen by `cfg_stat_empty` |
| above_upper | output | 1 | Level at or above the upper limit |
| below_lower | output | 1 | Level at or below the lower limit |

## Verification
The assertions watch, on every cycle, that no sample is removed while empty, while `txen` blocks gated reads or before automatic mode is armed, that the level moves by exactly one on a lone write or read, that the sticky flags set on their events and stay set until cleared, and that read data holds between reads. Only the bench's scenarios show the order of the data across a full fill and drain, the moment the automatic mode arms after the second write, the clear racing a new overflow, and the status output and threshold flags under changing limits; its reference model of queued samples is compared with every output on each clock.

// File: rtl/iq_fifo_pkg.sv
package iq_fifo_pkg;

  localparam int unsigned SAMP_W = 16;

  typedef struct packed {
    logic [SAMP_W-1:0] i;
    logic [SAMP_W-1:0] q;
  } iq_sample_t;

  // Next fill level from the accepted push/pop of this cycle.
  function automatic int unsigned fill_next(int unsigned cur, logic push, logic pop);
    int unsigned n;
    n = cur;
    if (push && !pop) n = cur + 1;
    else if (pop && !push) n = cur - 1;
    return n;
  endfunction

  function automatic logic at_or_above(int unsigned fill, int unsigned lim);
    return fill >= lim;
  endfunction

  function automatic logic at_or_below(int unsigned fill, int unsigned lim);
    return fill <= lim;
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/iq_fifo_store.sv
module iq_fifo_store
  import iq_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  iq_sample_t wdata,
  output iq_sample_t rdata
);

  iq_sample_t     mem [DEPTH];
  logic [AW-1:0]  wptr;
  logic [AW-1:0]  rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      rdata <= '0;
    end else begin
      if (push) wptr <= AW'(ptr_step(32'(wptr), DEPTH));
      if (pop) begin
        rdata <= mem[rptr];
        rptr  <= AW'(ptr_step(32'(rptr), DEPTH));
      end
    end
  end

endmodule

// File: rtl/iq_fifo_ctrl.sv
module iq_fifo_ctrl
  import iq_fifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned ARM_LEVEL = 2,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_req,
  input  logic          txen,
  input  logic          cfg_gate,
  input  logic          clr_flags,
  output logic          push,
  output logic          pop,
  output logic          rd_allow,
  output logic          armed,
  output logic          ovf_evt,
  output logic          udf_evt,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow,
  output logic          rd_valid
);

  logic [LW-1:0] level_nx;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign rd_allow = cfg_gate ? txen : armed;
  assign push     = wr_en && !full;
  assign pop      = rd_req && rd_allow && !empty;
  assign ovf_evt  = wr_en && full;
  assign udf_evt  = rd_req && rd_allow && empty;
  assign level_nx = LW'(fill_next(32'(level), push, pop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= '0;
      armed     <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      level     <= level_nx;
      armed     <= armed || at_or_above(32'(level_nx), ARM_LEVEL);
      overflow  <= ovf_evt || (overflow && !clr_flags);
      underflow <= udf_evt || (underflow && !clr_flags);
      rd_valid  <= pop;
    end
  end

endmodule

// File: rtl/iq_fifo_thresh.sv
module iq_fifo_thresh
  import iq_fifo_pkg::*;
#(
  parameter int unsigned LW    = 9,
  parameter int unsigned THR_W = 8
) (
  input  logic [LW-1:0]    level,
  input  logic [THR_W-1:0] thr_upper,
  input  logic [THR_W-1:0] thr_lower,
  output logic             above_upper,
  output logic             below_lower
);

  assign above_upper = at_or_above(32'(level), 32'(thr_upper));
  assign below_lower = at_or_below(32'(level), 32'(thr_lower));

endmodule

// File: rtl/iq_sample_fifo.sv
module iq_sample_fifo
  import iq_fifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned THR_W     = 8,
  parameter int unsigned ARM_LEVEL = 2,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SAMP_W-1:0] wr_i,
  input  logic [SAMP_W-1:0] wr_q,
  input  logic              rd_req,
  input  logic              txen,
  input  logic              cfg_txen_gate,
  input  logic              cfg_stat_empty,
  input  logic [THR_W-1:0]  thr_upper,
  input  logic [THR_W-1:0]  thr_lower,
  input  logic              clr_flags,
  output logic [SAMP_W-1:0] rd_i,
  output logic [SAMP_W-1:0] rd_q,
  output logic              rd_valid,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic              stat_out,
  output logic              above_upper,
  output logic              below_lower
);

  // Internal events, brought out by name for the checker.
  logic       push_w, pop_w, rd_allow_w, armed_w, ovf_evt_w, udf_evt_w;
  iq_sample_t wdata_w, rdata_w;

  assign wdata_w = '{i: wr_i, q: wr_q};

  iq_fifo_ctrl #(.DEPTH(DEPTH), .ARM_LEVEL(ARM_LEVEL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req), .txen(txen),
    .cfg_gate(cfg_txen_gate), .clr_flags(clr_flags),
    .push(push_w), .pop(pop_w), .rd_allow(rd_allow_w), .armed(armed_w),
    .ovf_evt(ovf_evt_w), .udf_evt(udf_evt_w), .level(level),
    .full(full), .empty(empty), .overflow(overflow), .underflow(underflow),
    .rd_valid(rd_valid)
  );

  iq_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
    .wdata(wdata_w), .rdata(rdata_w)
  );

  iq_fifo_thresh #(.LW(LW), .THR_W(THR_W)) u_thresh (
    .level(level), .thr_upper(thr_upper), .thr_lower(thr_lower),
    .above_upper(above_upper), .below_lower(below_lower)
  );

  assign rd_i     = rdata_w.i;
  assign rd_q     = rdata_w.q;
  assign stat_out = cfg_stat_empty ? empty : underflow;

endmodule

// File: rtl/iq_sample_fifo_chk.sv
module iq_sample_fifo_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_req,
  input logic          txen,
  input logic          cfg_txen_gate,
  input logic          clr_flags,
  input logic          push,
  input logic          pop,
  input logic          rd_allow,
  input logic          armed,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          underflow,
  input logic          rd_valid,
  input logic [31:0]   rd_data
);

  a_r1_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rd_valid);

  a_r1_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> $stable(rd_data));

  a_r2_no_read_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_txen_gate && !armed) |-> !pop);

  a_r3_txen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_txen_gate && !txen) |-> (!pop && !rd_allow));

  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LW'(DEPTH)) && $onehot0({full, empty}));

  a_r4_push_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (level == $past(level) + 1'b1));

  a_r4_pop_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (level == $past(level) - 1'b1));

  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  a_r5_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  a_r6_udf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_allow && empty) |=> underflow);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_flags) |=> overflow);

  a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !clr_flags) |=> underflow);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !wr_en && !rd_req) |=> (!overflow && !underflow));

endmodule

bind iq_sample_fifo iq_sample_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req), .txen(txen),
  .cfg_txen_gate(cfg_txen_gate), .clr_flags(clr_flags),
  .push(push_w), .pop(pop_w), .rd_allow(rd_allow_w), .armed(armed_w),
  .level(level), .full(full), .empty(empty), .overflow(overflow),
  .underflow(underflow), .rd_valid(rd_valid), .rd_data({rd_i, rd_q})
);

// File: tb/iq_sample_fifo_tb.sv
module iq_sample_fifo_tb;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, rd_req = 0, txen = 0, cfg_txen_gate = 0;
  logic        cfg_stat_empty = 0, clr_flags = 0;
  logic [15:0] wr_i = 0, wr_q = 0;
  logic [7:0]  thr_upper = 8'd200, thr_lower = 8'd10;
  logic [15:0] rd_i, rd_q;
  logic        rd_valid, full, empty, overflow, underflow, stat_out;
  logic        above_upper, below_lower;
  logic [8:0]  level;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_q[$];
  logic [31:0] m_data;
  bit m_valid, m_arm, m_ovf, m_udf;
  int seq = 0;

  always #2.5 clk = ~clk;

  iq_sample_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
    .rd_req(rd_req), .txen(txen), .cfg_txen_gate(cfg_txen_gate),
    .cfg_stat_empty(cfg_stat_empty), .thr_upper(thr_upper), .thr_lower(thr_lower),
    .clr_flags(clr_flags), .rd_i(rd_i), .rd_q(rd_q), .rd_valid(rd_valid),
    .level(level), .full(full), .empty(empty), .overflow(overflow),
    .underflow(underflow), .stat_out(stat_out), .above_upper(above_upper),
    .below_lower(below_lower)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit allow, pop, push;
    int sz;
    if (!rst_n) begin
      m_q.delete(); m_data = 0; m_valid = 0; m_arm = 0; m_ovf = 0; m_udf = 0;
      return;
    end
    sz    = m_q.size();
    allow = cfg_txen_gate ? txen : m_arm;
    pop   = rd_req && allow && sz > 0;
    push  = wr_en && sz < DEPTH;
    m_ovf = (wr_en && sz == DEPTH) || (m_ovf && !clr_flags);
    m_udf = (rd_req && allow && sz == 0) || (m_udf && !clr_flags);
    m_valid = pop;
    if (pop) m_data = m_q.pop_front();
    if (push) m_q.push_back({wr_i, wr_q});
    if (m_q.size() >= 2) m_arm = 1;
  endtask

  task automatic compare_all();
    int sz;
    sz = m_q.size();
    chk(int'(level) == sz, "R4 level", level, sz);
    chk(full == (sz == DEPTH), "R4 full", full, sz == DEPTH);
    chk(empty == (sz == 0), "R4 empty", empty, sz == 0);
    chk(overflow == m_ovf, "R5 overflow", overflow, m_ovf);
    chk(underflow == m_udf, "R6 underflow", underflow, m_udf);
    chk(stat_out == (cfg_stat_empty ? (sz == 0) : m_udf), "R8 stat_out", stat_out,
        cfg_stat_empty ? (sz == 0) : m_udf);
    chk(above_upper == (sz >= int'(thr_upper)), "R9 above_upper", above_upper, sz >= int'(thr_upper));
    chk(below_lower == (sz <= int'(thr_lower)), "R9 below_lower", below_lower, sz <= int'(thr_lower));
    chk(rd_valid == m_valid, "R1 rd_valid", rd_valid, m_valid);
    chk({rd_i, rd_q} == m_data, "R1 rd_data", {rd_i, rd_q}, m_data);
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
      if (wr_en) begin seq++; wr_i = 16'(seq); wr_q = ~16'(seq); end
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_req = 0; clr_flags = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wr_i = 16'h0001; wr_q = 16'hfffe; seq = 1;
    cyc(3);
    // R10: reset state
    chk(empty == 1 && level == 0, "R10 reset empty", level, 0);
    chk(!overflow && !underflow && !rd_valid, "R10 reset flags", {overflow, underflow, rd_valid}, 0);
    chk({rd_i, rd_q} == 0, "R10 reset data", {rd_i, rd_q}, 0);
    rst_n = 1'b1;
    cyc(1);

    // R2: one write, read ignored while disarmed (txen high must not matter)
    wr_en = 1; cyc(1); idle();
    rd_req = 1; txen = 1; cyc(1); rd_req = 0; txen = 0;
    chk(rd_valid == 0 && level == 1, "R2 read ignored before arm", level, 1);
    chk(underflow == 0, "R2 no underflow before arm", underflow, 0);
    wr_en = 1; cyc(1); idle();
    rd_req = 1; cyc(1); rd_req = 0;
    chk(rd_valid == 1 && level == 1, "R2 read after arm", level, 1);
    chk(rd_i == 16'd1, "R1 first sample out", rd_i, 1);
    cyc(1);
    chk(rd_valid == 0 && rd_i == 16'd1, "R1 data holds", rd_i, 1);

    // R5: fill past full
    thr_upper = 8'd200; thr_lower = 8'd10;
    wr_en = 1; cyc(DEPTH + 2); idle();
    chk(full == 1 && overflow == 1, "R5 full and overflow", {full, overflow}, 2'b11);
    // R4: write and read together while not full -> level unchanged
    rd_req = 1; cyc(1); rd_req = 0;
    wr_en = 1; rd_req = 1; cyc(1); idle();
    chk(int'(level) == DEPTH - 1, "R4 simultaneous keeps level", level, DEPTH - 1);
    // R5: write while full with concurrent read is dropped
    wr_en = 1; cyc(1); idle();
    wr_en = 1; rd_req = 1; cyc(1); idle();
    chk(int'(level) == DEPTH - 1, "R5 full write dropped with read", level, DEPTH - 1);

    // R7: clear races a new overflow event
    wr_en = 1; cyc(1); idle();
    wr_en = 1; clr_flags = 1; cyc(1); idle();
    chk(overflow == 1, "R7 event beats clear", overflow, 1);
    clr_flags = 1; cyc(1); idle();
    chk(overflow == 0, "R7 clear", overflow, 0);

    // R6/R8: drain to underflow, watch stat_out in both selections
    cfg_stat_empty = 1;
    rd_req = 1; cyc(DEPTH + 2); rd_req = 0;
    chk(underflow == 1 && empty == 1, "R6 underflow sticky", underflow, 1);
    chk(stat_out == 1, "R8 stat shows empty", stat_out, 1);
    cyc(2);
    cfg_stat_empty = 0; cyc(1);
    chk(stat_out == 1, "R8 stat shows underflow", stat_out, 1);
    clr_flags = 1; cyc(1); idle();
    chk(stat_out == 0, "R8 stat after clear", stat_out, 0);

    // R3: gated mode
    cfg_txen_gate = 1; txen = 0;
    rd_req = 1; cyc(3); rd_req = 0;
    chk(underflow == 0, "R3 gated empty read no underflow", underflow, 0);
    wr_en = 1; cyc(4); idle();
    rd_req = 1; cyc(3); rd_req = 0;
    chk(level == 4 && rd_valid == 0, "R3 txen low blocks", level, 4);
    txen = 1; rd_req = 1; cyc(1); rd_req = 0; txen = 0;
    chk(level == 3 && rd_valid == 1, "R3 txen high reads", level, 3);

    // R9: threshold sweep
    thr_upper = 8'd3; thr_lower = 8'd3; cyc(1);
    chk(above_upper && below_lower, "R9 equal limits", {above_upper, below_lower}, 2'b11);
    thr_upper = 8'd4; thr_lower = 8'd2; cyc(1);
    chk(!above_upper && !below_lower, "R9 between limits", {above_upper, below_lower}, 0);

    // mixed random traffic, all outputs compared each clock
    for (int n = 0; n < 4000; n++) begin
      wr_en = ($urandom_range(0, 99) < 55);
      rd_req = ($urandom_range(0, 99) < 50);
      txen = ($urandom_range(0, 3) != 0);
      clr_flags = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 199) == 0) cfg_txen_gate = ~cfg_txen_gate;
      if ($urandom_range(0, 99) == 0) cfg_stat_empty = ~cfg_stat_empty;
      if ($urandom_range(0, 63) == 0) begin
        thr_upper = 8'($urandom); thr_lower = 8'($urandom);
      end
      cyc(1);
    end
    idle();
    // R10: reset again mid-run
    rst_n = 0; cyc(1);
    chk(empty && !overflow && !underflow, "R10 second reset", {empty, overflow, underflow}, 3'b100);
    rst_n = 1; cfg_txen_gate = 0;
    wr_en = 1; cyc(1); idle();
    rd_req = 1; cyc(1); rd_req = 0;
    chk(rd_valid == 0, "R2 disarmed after reset", rd_valid, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule